// File: doc/BRIEF.md
# Alarm-Triggered Pretrigger Capture Recorder

This block records a short window of sensor samples around an impact or threshold event. Two threshold alarms each compare one selectable sample stream against a signed 14-bit limit, in either direction. While the recorder waits, it writes every strobed sample into a circular store. Once enough samples have gone in to fill the programmed pretrigger region, the first strobe on which either alarm condition holds becomes the trigger. The recorder then keeps writing until the capture window of 2^N samples is complete, and it stops for good.

Two capture channels share the trigger and the write position. Each channel stores its own selectable stream, which can differ from the stream that triggers it. Every stored word carries the alarm state at that sample, so the point where the trigger fell can be seen in the data. Readout goes through a shared pointer that starts at 1. The pointer steps forward on each read from either port and can also be loaded directly. After a capture completes, pointer value 1 addresses the oldest retained sample, whatever the final circular write position was.

Top module: `capture_recorder`

## Requirements
- R1: An alarm word holds the direction in bit 15 and a signed 14-bit threshold in bits 13:0. Bit 15 set means the alarm holds when the sample is greater than the threshold; bit 15 clear means it holds when the sample is less than the threshold. The 4-bit source codes are: 0001 supply (bus slot 0), 0010 X (slot 1), 0011 Y (slot 2), 0100 auxiliary input (slot 3), 0101 temperature (slot 4) and 1000 magnitude (slot 5). Any other code disables the alarm. `alm_act` bit 0 (alarm 1) and bit 1 (alarm 2) are registered on every strobe.
- R2: Each capture channel stores the stream chosen by its own source code, using the same codes, independently of the alarm sources. A disabled code stores 0.
- R3: The capture length is 2^N samples, where N is `cap_cfg[3:0]` clamped to the range 3..AW. N and P are latched on the first strobe after reset or after a clear.
- R4: The pretrigger count is 2^P, where P is `cap_cfg[7:4]`, limited to the capture length. When P >= N, the capture ends on the trigger strobe and that strobe is not stored.
- R5: A trigger is accepted only once at least the pretrigger count of samples has been stored. The trigger strobe is the first post-trigger sample.
- R6: A read word is {0, alarm state, data}: bit 15 is 0, bit 14 is alarm1 OR alarm2 at that sample, and bits 13:0 are the sample.
- R7: Once complete, the store holds the last 2^N strobed samples. Pointer k returns the k-th oldest of these, modulo 2^N. Locations not written since reset or a clear read as 0.
- R8: `buf_full` rises when a capture completes. Until a clear, no further sample is stored.
- R9: `rd_ptr` stays within 1..2^AW and resets to 1. A strobe on `rd_stb1` or `rd_stb2` advances it, wrapping from 2^AW to 1.
- R10: `ptr_wr` loads `ptr_wdata` when the value lies in 1..2^AW and is ignored otherwise. A valid load wins over a same-cycle read advance.
- R11: `cmd_ptr_rst` sets the pointer to 1 and wins over a same-cycle load.
- R12: `cmd_buf_clr` makes every location read 0, drops `buf_full` and re-arms the recorder. It wins over a same-cycle strobe and leaves the pointer unchanged.
- R13: A `cap_cfg` value of 0x327A selects a 1024-sample capture with 128 pretrigger samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | New sample set present on `src_bus` |
| src_bus | input | 84 | Six 14-bit sample slots (supply, X, Y, aux, temp, magnitude) |
| alm1_cfg | input | 16 | Alarm 1 direction and threshold |
| alm2_cfg | input | 16 | Alarm 2 direction and threshold |
| alm1_src | input | 4 | Alarm 1 source code |
| alm2_src | input | 4 | Alarm 2 source code |
| cap1_src | input | 4 | Channel 1 capture source code |
| cap2_src | input | 4 | Channel 2 capture source code |
| cap_cfg | input | 16 | N in bits 3:0, P in bits 7:4 |
| ptr_wr | input | 1 | Load the read pointer |
| ptr_wdata | input | 11 | Pointer load value |
| cmd_ptr_rst | input | 1 | Set the pointer to 1 |
| cmd_buf_clr | input | 1 | Empty the store and re-arm |
| rd_stb1 | input | 1 | Read from port 1 (advances the pointer) |
| rd_stb2 | input | 1 | Read from port 2 (advances the pointer) |
| rd_data1 | output | 16 | Channel 1 word at the pointer |
| rd_data2 | output | 16 | Channel 2 word at the pointer |
| alm_act | output | 2 | Alarm states from the last strobe |
| buf_full | output | 1 | Capture complete |
| rd_ptr | output | 11 | Current read pointer |

## Verification
A ramp that crosses a greater-than threshold long after the pretrigger region has filled shows whether the final circular rotation and the marker boundary are placed correctly. An alarm that is already true from the first sample shows whether early triggers are held off until the pretrigger count is met. A negative-going less-than crossing, with N below its floor and P above N, separates correct clamping and truncation from a raw field decode; a disabled second alarm with a permissive threshold must stay silent in that run. A full 1024-sample capture on the magnitude stream exercises pointer wrap, rejected loads, command priorities and a clear that coincides with a strobe, and a behavioural model is compared against every output on every clock.

// File: rtl/capture_recorder.sv
module capture_recorder #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic [83:0]   src_bus,
  input  logic [15:0]   alm1_cfg,
  input  logic [15:0]   alm2_cfg,
  input  logic [3:0]    alm1_src,
  input  logic [3:0]    alm2_src,
  input  logic [3:0]    cap1_src,
  input  logic [3:0]    cap2_src,
  input  logic [15:0]   cap_cfg,
  input  logic          ptr_wr,
  input  logic [AW:0]   ptr_wdata,
  input  logic          cmd_ptr_rst,
  input  logic          cmd_buf_clr,
  input  logic          rd_stb1,
  input  logic          rd_stb2,
  output logic [15:0]   rd_data1,
  output logic [15:0]   rd_data2,
  output logic [1:0]    alm_act,
  output logic          buf_full,
  output logic [AW:0]   rd_ptr
);
  localparam int DW    = 14;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [15:0] VALIDM = 16'h013E;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_POST, S_DONE} st_t;

  st_t             st;
  logic [3:0]      n_q, p_q, n_e, p_e;
  logic [PW-1:0]   len, pre, post, fill, post_left;
  logic [AW-1:0]   mask, wr_idx, raddr;
  logic [DW-1:0]   lane [16];
  logic            a1, a2, mark, fire, we, rvalid;
  logic [DW:0]     mem1 [DEPTH];
  logic [DW:0]     mem2 [DEPTH];

  wire unused_bits = &{1'b0, alm1_cfg[14], alm2_cfg[14], cap_cfg[15:8]};

  for (genvar k = 0; k < 16; k++) begin : g_lane
    if (k >= 1 && k <= 5) begin : g_std
      assign lane[k] = src_bus[(k-1)*DW +: DW];
    end else if (k == 8) begin : g_mag
      assign lane[k] = src_bus[5*DW +: DW];
    end else begin : g_off
      assign lane[k] = '0;
    end
  end

  function automatic logic [3:0] clampn(input logic [3:0] n);
    if (n < 4'd3) return 4'd3;
    else if (n > 4'(AW)) return 4'(AW);
    else return n;
  endfunction

  function automatic logic hit(input logic [15:0] c, input logic [DW-1:0] v, input logic en);
    if (!en) return 1'b0;
    return c[15] ? ($signed(v) > $signed(c[13:0])) : ($signed(v) < $signed(c[13:0]));
  endfunction

  assign n_e  = (st == S_IDLE) ? clampn(cap_cfg[3:0]) : n_q;
  assign p_e  = (st == S_IDLE) ? cap_cfg[7:4] : p_q;
  assign len  = PW'(1) << n_e;
  assign pre  = (p_e >= n_e) ? len : (PW'(1) << p_e);
  assign post = len - pre;
  assign mask = AW'(len - PW'(1));

  assign a1   = hit(alm1_cfg, lane[alm1_src], VALIDM[alm1_src]);
  assign a2   = hit(alm2_cfg, lane[alm2_src], VALIDM[alm2_src]);
  assign mark = a1 | a2;
  assign fire = mark && (fill >= pre);

  always_comb begin
    we = 1'b0;
    if (smp_stb && !cmd_buf_clr) begin
      case (st)
        S_IDLE:  we = 1'b1;
        S_PRE:   we = !(fire && post == '0);
        S_POST:  we = 1'b1;
        default: we = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      n_q       <= 4'd3;
      p_q       <= 4'd0;
      fill      <= '0;
      wr_idx    <= '0;
      post_left <= '0;
      alm_act   <= 2'b00;
    end else begin
      if (smp_stb) alm_act <= {a2, a1};
      if (cmd_buf_clr) begin
        st        <= S_IDLE;
        fill      <= '0;
        wr_idx    <= '0;
        post_left <= '0;
      end else if (smp_stb) begin
        case (st)
          S_IDLE: begin
            n_q <= n_e;
            p_q <= p_e;
            st  <= S_PRE;
          end
          S_PRE: if (fire) begin
            if (post <= PW'(1)) st <= S_DONE;
            else begin
              st        <= S_POST;
              post_left <= post - PW'(1);
            end
          end
          S_POST: begin
            post_left <= post_left - PW'(1);
            if (post_left == PW'(1)) st <= S_DONE;
          end
          default: ;
        endcase
        if (we) begin
          wr_idx <= (wr_idx + AW'(1)) & mask;
          if (fill != len) fill <= fill + PW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem1[wr_idx] <= {mark, lane[cap1_src]};
      mem2[wr_idx] <= {mark, lane[cap2_src]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ptr <= PW'(1);
    else if (cmd_ptr_rst) rd_ptr <= PW'(1);
    else if (ptr_wr && ptr_wdata != '0 && ptr_wdata <= PW'(DEPTH)) rd_ptr <= ptr_wdata;
    else if (rd_stb1 || rd_stb2) rd_ptr <= (rd_ptr == PW'(DEPTH)) ? PW'(1) : rd_ptr + PW'(1);
  end

  assign raddr    = (wr_idx + rd_ptr[AW-1:0] - AW'(1)) & mask;
  assign rvalid   = (fill == len) || ({1'b0, raddr} < fill);
  assign rd_data1 = rvalid ? {1'b0, mem1[raddr]} : 16'h0000;
  assign rd_data2 = rvalid ? {1'b0, mem2[raddr]} : 16'h0000;
  assign buf_full = (st == S_DONE);

  p_ptr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr >= PW'(1) && rd_ptr <= PW'(DEPTH));

  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb1 || rd_stb2) && !cmd_ptr_rst && !ptr_wr |=>
    rd_ptr == (($past(rd_ptr) == PW'(DEPTH)) ? PW'(1) : $past(rd_ptr) + PW'(1)));

  p_ptr_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ptr_rst |=> rd_ptr == PW'(1));

  p_single_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && !cmd_buf_clr |=> buf_full && $stable(wr_idx) && $stable(fill));

  p_done_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> fill == len);

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_buf_clr |=> !buf_full && rd_data1 == 16'h0000 && rd_data2 == 16'h0000);
endmodule

// File: tb/capture_recorder_tb.sv
`timescale 1ns/1ps
module capture_recorder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic [83:0] src_bus = '0;
  logic [15:0] alm1_cfg = '0, alm2_cfg = '0, cap_cfg = '0;
  logic [3:0] alm1_src = '0, alm2_src = '0, cap1_src = '0, cap2_src = '0;
  logic ptr_wr = 1'b0, cmd_ptr_rst = 1'b0, cmd_buf_clr = 1'b0, rd_stb1 = 1'b0, rd_stb2 = 1'b0;
  logic [10:0] ptr_wdata = '0;
  logic [15:0] rd_data1, rd_data2;
  logic [1:0] alm_act;
  logic buf_full;
  logic [10:0] rd_ptr;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  capture_recorder u_dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .src_bus(src_bus),
    .alm1_cfg(alm1_cfg), .alm2_cfg(alm2_cfg), .alm1_src(alm1_src), .alm2_src(alm2_src),
    .cap1_src(cap1_src), .cap2_src(cap2_src), .cap_cfg(cap_cfg),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .cmd_ptr_rst(cmd_ptr_rst), .cmd_buf_clr(cmd_buf_clr),
    .rd_stb1(rd_stb1), .rd_stb2(rd_stb2), .rd_data1(rd_data1), .rd_data2(rd_data2),
    .alm_act(alm_act), .buf_full(buf_full), .rd_ptr(rd_ptr));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st = 0, m_L = 8, m_pre = 1, m_w = 0, m_left = 0, m_ptr = 1, m_alm = 0;
  int q1[$], q2[$];

  function automatic int lane(input int code);
    int slot;
    if (code >= 1 && code <= 5) slot = code - 1;
    else if (code == 8) slot = 5;
    else return 0;
    return int'((src_bus >> (slot * 14)) & 84'h3FFF);
  endfunction

  function automatic int s14(input int v);
    return (v >= 8192) ? v - 16384 : v;
  endfunction

  function automatic bit alarm(input logic [15:0] c, input int code);
    int v, t;
    if (!(code inside {1, 2, 3, 4, 5, 8})) return 1'b0;
    v = s14(lane(code));
    t = s14(int'(c[13:0]));
    return c[15] ? (v > t) : (v < t);
  endfunction

  function automatic int ridx();
    int a;
    if (m_w == 0) return -1;
    if (m_w >= m_L) return (m_ptr - 1) % m_L;
    a = (m_w + m_ptr - 1) % m_L;
    return (a < m_w) ? a : -1;
  endfunction

  task automatic m_push(input int mk);
    q1.push_back((mk << 14) | lane(int'(cap1_src)));
    q2.push_back((mk << 14) | lane(int'(cap2_src)));
    m_w++;
    if (q1.size() > m_L) begin
      void'(q1.pop_front());
      void'(q2.pop_front());
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_w = 0; m_ptr = 1; m_alm = 0; m_left = 0;
      q1.delete(); q2.delete();
    end else begin
      bit b1, b2;
      int mk, n, p;
      b1 = alarm(alm1_cfg, int'(alm1_src));
      b2 = alarm(alm2_cfg, int'(alm2_src));
      mk = int'(b1 | b2);
      if (cmd_ptr_rst) m_ptr = 1;
      else if (ptr_wr && ptr_wdata >= 1 && ptr_wdata <= 1024) m_ptr = int'(ptr_wdata);
      else if (rd_stb1 || rd_stb2) m_ptr = (m_ptr == 1024) ? 1 : m_ptr + 1;
      if (smp_stb) m_alm = {b2, b1};
      if (cmd_buf_clr) begin
        m_st = 0; m_w = 0;
        q1.delete(); q2.delete();
      end else if (smp_stb) begin
        case (m_st)
          0: begin
            n = int'(cap_cfg[3:0]);
            if (n < 3) n = 3;
            if (n > 10) n = 10;
            p = int'(cap_cfg[7:4]);
            m_L = 1 << n;
            m_pre = (p >= n) ? m_L : (1 << p);
            m_push(mk);
            m_st = 1;
          end
          1: begin
            if (mk == 1 && m_w >= m_pre) begin
              if (m_L == m_pre) m_st = 3;
              else begin
                m_push(mk);
                m_left = m_L - m_pre - 1;
                m_st = (m_left == 0) ? 3 : 2;
              end
            end else m_push(mk);
          end
          2: begin
            m_push(mk);
            m_left--;
            if (m_left == 0) m_st = 3;
          end
          default: ;
        endcase
      end
    end
    #1;
    begin
      int ix;
      ix = ridx();
      chk("R7 model port1", int'(rd_data1), ix < 0 ? 0 : q1[ix]);
      chk("R7 model port2", int'(rd_data2), ix < 0 ? 0 : q2[ix]);
      chk("R1 model alarms", int'(alm_act), m_alm);
      chk("R8 model full", int'(buf_full), int'(m_st == 3));
      chk("R9 model pointer", int'(rd_ptr), m_ptr);
    end
  end

  task automatic set_lanes(input int x, input int y, input int mag);
    src_bus = {14'(mag), 14'd25, 14'd77, 14'(y), 14'(x), 14'd3300};
  endtask

  task automatic strobe(input int x, input int y, input int mag);
    set_lanes(x, y, mag);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic clr();
    cmd_buf_clr = 1'b1;
    @(negedge clk);
    cmd_buf_clr = 1'b0;
  endtask

  task automatic ptrrst();
    cmd_ptr_rst = 1'b1;
    @(negedge clk);
    cmd_ptr_rst = 1'b0;
  endtask

  task automatic setptr(input int v);
    ptr_wr = 1'b1;
    ptr_wdata = 11'(v);
    @(negedge clk);
    ptr_wr = 1'b0;
  endtask

  task automatic rd1(input int exp, input string tag);
    chk(tag, int'(rd_data1), exp);
    rd_stb1 = 1'b1;
    @(negedge clk);
    rd_stb1 = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset pointer", int'(rd_ptr), 1);
    chk("R8 reset full", int'(buf_full), 0);
    chk("R1 reset alarms", int'(alm_act), 0);
    chk("R12 reset data", int'(rd_data1), 0);

    // ramp crossing a greater-than threshold, L=8, pre=4
    cap_cfg = 16'h0023; alm1_src = 4'd2; alm1_cfg = 16'h8064;
    alm2_src = 4'd0; alm2_cfg = 16'h0000; cap1_src = 4'd3; cap2_src = 4'd2;
    for (int j = 0; j < 15; j++) strobe(j * 10, 1000 + j, 0);
    chk("R8 full after window", int'(buf_full), 1);
    chk("R1 alarm one active", int'(alm_act), 1);
    ptrrst();
    chk("R2 channel two on X", int'(rd_data2), 70);
    for (int k = 1; k <= 8; k++)
      rd1(((6 + k >= 11) ? 16'h4000 : 0) | (1006 + k), "R7 rotated readout");
    chk("R9 pointer advanced", int'(rd_ptr), 9);
    for (int j = 0; j < 3; j++) strobe(999, 5, 0);
    ptrrst();
    chk("R8 single-shot full", int'(buf_full), 1);
    chk("R8 single-shot data", int'(rd_data1), 1007);

    // alarm true from the start: held off until pretrigger filled
    clr();
    chk("R12 clear full", int'(buf_full), 0);
    chk("R12 clear data", int'(rd_data1), 0);
    for (int j = 0; j < 7; j++) strobe(500, 1000 + j, 0);
    chk("R5 not yet full", int'(buf_full), 0);
    strobe(500, 1007, 0);
    chk("R5 full on eighth", int'(buf_full), 1);
    chk("R6 marker on oldest", int'(rd_data1), 16'h4000 | 1000);

    // less-than on negative Y, N clamped up, P truncated
    clr();
    cap_cfg = 16'h0051; alm1_src = 4'd3; alm1_cfg = 16'h3FFB;
    alm2_src = 4'd6; alm2_cfg = 16'h8000; cap1_src = 4'd3; cap2_src = 4'd0;
    for (int j = 0; j < 8; j++) strobe(5, 100 + j, 0);
    chk("R4 not full before trigger", int'(buf_full), 0);
    strobe(5, 16'h3FF6, 0);
    chk("R4 ends on trigger", int'(buf_full), 1);
    chk("R1 disabled code silent", int'(alm_act), 1);
    ptrrst();
    chk("R3 oldest of clamped length", int'(rd_data1), 100);
    chk("R2 disabled capture zero", int'(rd_data2), 0);
    setptr(8);
    chk("R4 last stored is pre", int'(rd_data1), 107);

    // full-size capture on magnitude
    clr();
    cap_cfg = 16'h327A; alm1_src = 4'd0; alm2_src = 4'd8; alm2_cfg = 16'h87D0;
    cap1_src = 4'd2; cap2_src = 4'd4;
    for (int j = 0; j < 1195; j++) strobe(j, 0, (j < 300) ? j : 5000);
    chk("R13 not full at 1195", int'(buf_full), 0);
    strobe(1195, 0, 5000);
    chk("R13 full at 1196", int'(buf_full), 1);
    chk("R1 alarm two active", int'(alm_act), 2);
    setptr(128);
    rd1(299, "R6 last pretrigger");
    rd1(16'h4000 | 300, "R6 first post-trigger");
    setptr(1);
    chk("R7 oldest sample", int'(rd_data1), 172);
    chk("R2 aux capture", int'(rd_data2), 77);
    setptr(1024);
    rd1(16'h4000 | 1195, "R7 newest sample");
    chk("R9 wrap to one", int'(rd_ptr), 1);
    setptr(0);
    chk("R10 zero load ignored", int'(rd_ptr), 1);
    setptr(1025);
    chk("R10 large load ignored", int'(rd_ptr), 1);
    ptr_wr = 1'b1; ptr_wdata = 11'd500; cmd_ptr_rst = 1'b1;
    @(negedge clk);
    ptr_wr = 1'b0; cmd_ptr_rst = 1'b0;
    chk("R11 reset beats load", int'(rd_ptr), 1);
    ptr_wr = 1'b1; ptr_wdata = 11'd600; rd_stb1 = 1'b1;
    @(negedge clk);
    ptr_wr = 1'b0; rd_stb1 = 1'b0;
    chk("R10 load beats advance", int'(rd_ptr), 600);

    // clear coinciding with a strobe
    set_lanes(1, 2, 3);
    cmd_buf_clr = 1'b1; smp_stb = 1'b1;
    @(negedge clk);
    cmd_buf_clr = 1'b0; smp_stb = 1'b0;
    chk("R12 clear wins full", int'(buf_full), 0);
    chk("R12 clear wins data", int'(rd_data1), 0);
    chk("R12 pointer kept", int'(rd_ptr), 600);
    strobe(9, 9, 9);
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule